// File: doc/BRIEF.md
# Lockstep Redundancy Output Checker

This block sits where two replicated processing channels leave their replicated region. It watches three checkpoints: the peripheral bus, the flash-memory path and the SRAM path. At each checkpoint it compares, on every clock cycle, the bundle that channel A presents against the bundle that channel B presents. A bundle is a valid strobe plus a data word carrying address, write data and control bits. When the two channels disagree, a sticky error flag for that checkpoint is set, and a single fault line toward the fault-collection logic rises.

The block runs in one of two modes. The mode is sampled from a strap input at the first clock edge after power-on reset is released, and it then stays fixed until the next power-on reset. In lockstep mode the comparison is active. In decoupled mode the channels run independently and no flag can be set.

Both channels pass through the same parameterised delay of 0 to 2 cycles, so that they are compared in the same cycle. A test-injection input flips one chosen bit of channel B's bundle at one chosen checkpoint, which lets software prove that the fault path works.

Top module: `lockstep_output_checker`

Control state machine:
- States: `ST_HOLD` (power-on reset asserted, or the first edge after its release not yet seen), `ST_LOCKSTEP` and `ST_DECOUPLED`.
- Transitions: `ST_HOLD` goes to `ST_LOCKSTEP` when `mode_strap`=0 at the first edge after `por_n` rises, and to `ST_DECOUPLED` when `mode_strap`=1 at that edge.
- `ST_LOCKSTEP` and `ST_DECOUPLED` hold until `por_n` goes low, which returns the machine to `ST_HOLD`.

## Requirements
- R1: At the first rising clock edge with `por_n` high, the mode is captured from `mode_strap`: 0 selects lockstep and drives `lockstep_active`=1; 1 selects decoupled and drives `lockstep_active`=0. While `por_n` is low, `lockstep_active` is 0.
- R2: Once captured, the mode does not change when `mode_strap` toggles or when warm reset `rst_n` is pulsed. Only `por_n` changes it.
- R3: In lockstep, checkpoint i is in mismatch when either valid bit is high and the valid bits differ or any bit of the two bundle slices differs. Checkpoint i uses bits `[i*BUNDLE_W +: BUNDLE_W]`, with index 0 for the peripheral bus, 1 for flash and 2 for SRAM. When both valid bits are low, bundle differences are ignored.
- R4: Identical valid bits and bundles on both channels never set a flag.
- R5: A mismatch presented at the inputs sets `err_flags[i]` and `fault` after exactly `ALIGN_LAG`+1 rising edges (2 with the default `ALIGN_LAG`=1). Neither is set earlier.
- R6: Each flag is sticky: warm reset does not clear it. A one on `clr_flags[i]` clears only flag i at the next edge. A new mismatch in the same cycle wins over the clear.
- R7: Each checkpoint sets only its own flag, and `fault` is high whenever any flag is high.
- R8: In decoupled mode no flag is ever set, whatever the inputs or the injection do.
- R9: With `inj_en`=1, bit `inj_bit` of channel B's bundle at checkpoint `inj_sel` is inverted before comparison. A value of `inj_sel` of `NUM_CP` or more injects nothing.
- R10: Power-on reset clears all flags and `fault` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Warm reset, active low; clears only the alignment delay |
| mode_strap | input | 1 | Mode selection: 0 = lockstep, 1 = decoupled |
| a_valid | input | NUM_CP | Channel A valid strobes, one per checkpoint |
| a_bundle | input | NUM_CP*BUNDLE_W | Channel A bundles, packed by checkpoint |
| b_valid | input | NUM_CP | Channel B valid strobes |
| b_bundle | input | NUM_CP*BUNDLE_W | Channel B bundles |
| inj_en | input | 1 | Enables test injection |
| inj_sel | input | SEL_W | Checkpoint to inject into |
| inj_bit | input | BIT_W | Bundle bit to invert |
| clr_flags | input | NUM_CP | Write-one-to-clear pulses from the fault unit |
| lockstep_active | output | 1 | High while in lockstep mode |
| err_flags | output | NUM_CP | Sticky per-checkpoint mismatch flags |
| fault | output | 1 | Fault toward the fault-collection unit |

## Verification
The hardest situation to reach from the ports is a decoupled-mode run. The strap is only sampled at the first edge after power-on reset, so the bench drives a full power-on reset with the strap high mid-test. Once decoupled, it applies mismatches on every checkpoint and an injection, and confirms that the flags stay clear. The bench also aims a clear pulse so that it lands after the delayed mismatch has left the alignment pipeline. This separates "clear works" from "set wins over clear".

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    typedef enum logic [1:0] {
        ST_HOLD      = 2'd0,
        ST_LOCKSTEP  = 2'd1,
        ST_DECOUPLED = 2'd2
    } lsc_state_e;
endpackage

// File: rtl/lsc_mode_ctrl.sv
module lsc_mode_ctrl
    import lsc_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic mode_strap,
    output logic cmp_en,
    output logic lockstep_active
);
    lsc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:      state_d = mode_strap ? ST_DECOUPLED : ST_LOCKSTEP;
            ST_LOCKSTEP:  state_d = ST_LOCKSTEP;
            ST_DECOUPLED: state_d = ST_DECOUPLED;
            default:      state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        cmp_en          = 1'b0;
        lockstep_active = 1'b0;
        unique case (state_q)
            ST_LOCKSTEP: begin
                cmp_en          = 1'b1;
                lockstep_active = 1'b1;
            end
            ST_HOLD, ST_DECOUPLED: begin
                cmp_en          = 1'b0;
                lockstep_active = 1'b0;
            end
            default: begin
                cmp_en          = 1'b0;
                lockstep_active = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lsc_lag_line.sv
module lsc_lag_line #(
    parameter int WIDTH = 8,
    parameter int LAG   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (LAG == 0) begin : g_direct
            logic unused_lag0;
            assign unused_lag0 = &{1'b0, clk, rst_n};
            assign q = d;
        end else begin : g_pipe
            logic [WIDTH-1:0] stage [LAG];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int k = 0; k < LAG; k++) stage[k] <= '0;
                end else begin
                    stage[0] <= d;
                    for (int k = 1; k < LAG; k++) stage[k] <= stage[k-1];
                end
            end
            assign q = stage[LAG-1];
        end
    endgenerate
endmodule

// File: rtl/lsc_cp_compare.sv
module lsc_cp_compare #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             cmp_en,
    input  logic             clr,
    input  logic             a_v,
    input  logic [WIDTH-1:0] a_d,
    input  logic             b_v,
    input  logic [WIDTH-1:0] b_d,
    output logic             flag
);
    logic mism;

    assign mism = (a_v | b_v) && ({a_v, a_d} != {b_v, b_d});

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              flag <= 1'b0;
        else if (cmp_en && mism) flag <= 1'b1;
        else if (clr)            flag <= 1'b0;
    end
endmodule

// File: rtl/lockstep_output_checker.sv
module lockstep_output_checker #(
    parameter int NUM_CP    = 3,
    parameter int BUNDLE_W  = 16,
    parameter int ALIGN_LAG = 1,
    localparam int SEL_W    = (NUM_CP > 1) ? $clog2(NUM_CP) : 1,
    localparam int BIT_W    = (BUNDLE_W > 1) ? $clog2(BUNDLE_W) : 1
) (
    input  logic                       clk,
    input  logic                       por_n,
    input  logic                       rst_n,
    input  logic                       mode_strap,
    input  logic [NUM_CP-1:0]          a_valid,
    input  logic [NUM_CP*BUNDLE_W-1:0] a_bundle,
    input  logic [NUM_CP-1:0]          b_valid,
    input  logic [NUM_CP*BUNDLE_W-1:0] b_bundle,
    input  logic                       inj_en,
    input  logic [SEL_W-1:0]           inj_sel,
    input  logic [BIT_W-1:0]           inj_bit,
    input  logic [NUM_CP-1:0]          clr_flags,
    output logic                       lockstep_active,
    output logic [NUM_CP-1:0]          err_flags,
    output logic                       fault
);
    localparam int PACK_W = NUM_CP * (BUNDLE_W + 1);

    logic                       cmp_en;
    logic                       pipe_rst_n;
    logic [NUM_CP*BUNDLE_W-1:0] b_injected;
    logic [PACK_W-1:0]          a_pack, b_pack, a_algn, b_algn;

    assign pipe_rst_n = por_n & rst_n;

    lsc_mode_ctrl u_mode (
        .clk             (clk),
        .por_n           (por_n),
        .mode_strap      (mode_strap),
        .cmp_en          (cmp_en),
        .lockstep_active (lockstep_active)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_CP; i++) begin : g_inj
            logic hit;
            assign hit = inj_en && (inj_sel == SEL_W'(i));
            assign b_injected[i*BUNDLE_W +: BUNDLE_W] =
                b_bundle[i*BUNDLE_W +: BUNDLE_W] ^
                (hit ? (BUNDLE_W'(1) << inj_bit) : '0);
        end
    endgenerate

    assign a_pack = {a_valid, a_bundle};
    assign b_pack = {b_valid, b_injected};

    lsc_lag_line #(.WIDTH(PACK_W), .LAG(ALIGN_LAG)) u_lag_a (
        .clk (clk), .rst_n (pipe_rst_n), .d (a_pack), .q (a_algn)
    );
    lsc_lag_line #(.WIDTH(PACK_W), .LAG(ALIGN_LAG)) u_lag_b (
        .clk (clk), .rst_n (pipe_rst_n), .d (b_pack), .q (b_algn)
    );

    generate
        for (i = 0; i < NUM_CP; i++) begin : g_cp
            lsc_cp_compare #(.WIDTH(BUNDLE_W)) u_cmp (
                .clk    (clk),
                .por_n  (por_n),
                .cmp_en (cmp_en),
                .clr    (clr_flags[i]),
                .a_v    (a_algn[NUM_CP*BUNDLE_W + i]),
                .a_d    (a_algn[i*BUNDLE_W +: BUNDLE_W]),
                .b_v    (b_algn[NUM_CP*BUNDLE_W + i]),
                .b_d    (b_algn[i*BUNDLE_W +: BUNDLE_W]),
                .flag   (err_flags[i])
            );
        end
    endgenerate

    assign fault = |err_flags;
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
    parameter int NUM_CP = 3
) (
    input logic              clk,
    input logic              por_n,
    input logic [NUM_CP-1:0] clr_flags,
    input logic              lockstep_active,
    input logic [NUM_CP-1:0] err_flags,
    input logic              fault
);
    logic started;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!por_n)
        started |=> $stable(lockstep_active));

    assert_decoupled_silent_R8: assert property (@(posedge clk) disable iff (!por_n)
        (started && !lockstep_active) |-> (err_flags == '0));

    assert_fault_needs_lockstep_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(fault) |-> lockstep_active);

    assert_fault_covers_flags_R7: assert property (@(posedge clk) disable iff (!por_n)
        (err_flags != '0) |-> fault);

    genvar i;
    generate
        for (i = 0; i < NUM_CP; i++) begin : g_sticky
            assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
                (err_flags[i] && !clr_flags[i]) |=> err_flags[i]);
        end
    endgenerate
endmodule

bind lockstep_output_checker lsc_checker #(.NUM_CP(NUM_CP)) u_lsc_chk (
    .clk             (clk),
    .por_n           (por_n),
    .clr_flags       (clr_flags),
    .lockstep_active (lockstep_active),
    .err_flags       (err_flags),
    .fault           (fault)
);

// File: tb/lockstep_output_checker_test.sv
`timescale 1ns/1ps
module lockstep_output_checker_test;
    localparam int NCP = 3;
    localparam int W   = 16;
    localparam int LAG = 1;

    logic           clk = 1'b0;
    logic           por_n, rst_n, mode_strap, inj_en;
    logic [NCP-1:0] a_valid, b_valid, clr_flags;
    logic [NCP*W-1:0] a_bundle, b_bundle;
    logic [1:0]     inj_sel;
    logic [3:0]     inj_bit;
    logic           lockstep_active, fault;
    logic [NCP-1:0] err_flags;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    lockstep_output_checker #(.NUM_CP(NCP), .BUNDLE_W(W), .ALIGN_LAG(LAG)) uut (
        .clk (clk), .por_n (por_n), .rst_n (rst_n), .mode_strap (mode_strap),
        .a_valid (a_valid), .a_bundle (a_bundle), .b_valid (b_valid), .b_bundle (b_bundle),
        .inj_en (inj_en), .inj_sel (inj_sel), .inj_bit (inj_bit), .clr_flags (clr_flags),
        .lockstep_active (lockstep_active), .err_flags (err_flags), .fault (fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_equal(input logic [W-1:0] seed);
        for (int i = 0; i < NCP; i++) begin
            a_valid[i] = 1'b1;
            b_valid[i] = 1'b1;
            a_bundle[i*W +: W] = seed ^ W'(i * 16'h1111);
            b_bundle[i*W +: W] = seed ^ W'(i * 16'h1111);
        end
    endtask

    task automatic settle();
        drive_equal(16'h0F0F);
        inj_en = 1'b0;
        cycles(LAG + 2);
    endtask

    task automatic clear_all();
        clr_flags = '1;
        cycles(1);
        clr_flags = '0;
    endtask

    task automatic power_on(input logic strap);
        por_n = 1'b0;
        mode_strap = strap;
        drive_equal(16'h0000);
        cycles(2);
        check("R10 flags cleared in POR", err_flags, 0);
        check("R10 fault low in POR", fault, 0);
        check("R1 mode inactive in POR", lockstep_active, 0);
        por_n = 1'b1;
        cycles(1);
        check("R1 mode captured", lockstep_active, strap ? 0 : 1);
    endtask

    task automatic t_equal();
        for (int k = 0; k < 4; k++) begin
            drive_equal(W'(16'h1234 * (k + 3)));
            cycles(LAG + 1);
            check("R4 equal bundles", err_flags, 0);
        end
    endtask

    task automatic t_bit_mismatch();
        drive_equal(16'hA5A5);
        b_bundle[1*W + 9] = ~b_bundle[1*W + 9];
        cycles(LAG);
        check("R5 not yet flagged", err_flags, 0);
        cycles(1);
        check("R3 bit mismatch flash", err_flags, 3'b010);
        check("R7 fault raised", fault, 1);
        settle();
        check("R6 flag sticky", err_flags, 3'b010);
        rst_n = 1'b0;
        cycles(1);
        rst_n = 1'b1;
        cycles(1);
        check("R6 warm reset keeps flag", err_flags, 3'b010);
        check("R2 warm reset keeps mode", lockstep_active, 1);
        clr_flags = 3'b001;
        cycles(1);
        clr_flags = '0;
        check("R6 clear other bit no effect", err_flags, 3'b010);
        clr_flags = 3'b010;
        cycles(1);
        clr_flags = '0;
        check("R6 clear flag", err_flags, 0);
        check("R7 fault drops", fault, 0);
    endtask

    task automatic t_valid_cases();
        drive_equal(16'h3C3C);
        b_valid[0] = 1'b0;
        cycles(LAG + 1);
        check("R3 valid mismatch periph", err_flags, 3'b001);
        settle();
        clear_all();
        drive_equal(16'h3C3C);
        a_valid[2] = 1'b0;
        b_valid[2] = 1'b0;
        b_bundle[2*W +: W] = 16'hDEAD;
        cycles(LAG + 1);
        check("R3 both invalid ignored", err_flags, 0);
        b_valid[2] = 1'b1;
        cycles(LAG + 1);
        check("R7 sram own flag", err_flags, 3'b100);
        b_bundle[0*W] = ~b_bundle[0*W];
        cycles(LAG + 1);
        check("R7 two checkpoints", err_flags, 3'b101);
        settle();
        clear_all();
        check("R6 all cleared", err_flags, 0);
    endtask

    task automatic t_strap_runtime();
        mode_strap = 1'b1;
        cycles(3);
        check("R2 strap toggle ignored", lockstep_active, 1);
        mode_strap = 1'b0;
    endtask

    task automatic t_inject();
        drive_equal(16'h7777);
        inj_sel = 2'd2;
        inj_bit = 4'd5;
        inj_en  = 1'b1;
        cycles(LAG + 1);
        check("R9 inject sram", err_flags, 3'b100);
        settle();
        clear_all();
        inj_sel = 2'd3;
        inj_en  = 1'b1;
        cycles(LAG + 1);
        check("R9 out of range select", err_flags, 0);
        settle();
    endtask

    task automatic t_decoupled();
        power_on(1'b1);
        drive_equal(16'h5555);
        b_valid = '0;
        b_bundle = ~a_bundle;
        cycles(LAG + 2);
        check("R8 decoupled no flags", err_flags, 0);
        check("R8 decoupled no fault", fault, 0);
        drive_equal(16'h5555);
        inj_sel = 2'd0;
        inj_bit = 4'd0;
        inj_en  = 1'b1;
        cycles(LAG + 2);
        check("R8 decoupled inject ignored", err_flags, 0);
        inj_en = 1'b0;
        mode_strap = 1'b0;
        rst_n = 1'b0;
        cycles(1);
        rst_n = 1'b1;
        cycles(1);
        check("R2 decoupled kept after warm reset", lockstep_active, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        por_n = 1'b0; rst_n = 1'b1; mode_strap = 1'b0;
        a_valid = '0; b_valid = '0; a_bundle = '0; b_bundle = '0;
        inj_en = 1'b0; inj_sel = '0; inj_bit = '0; clr_flags = '0;
        power_on(1'b0);
        t_equal();
        t_bit_mismatch();
        t_valid_cases();
        t_strap_runtime();
        t_inject();
        drive_equal(16'h1111);
        b_bundle[1*W] = ~b_bundle[1*W];
        cycles(LAG + 1);
        check("R5 flag before POR", err_flags, 3'b010);
        t_decoupled();
        power_on(1'b0);
        check("R10 flags clear after POR", err_flags, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule